// File: doc/BRIEF.md
# IDE PIO Register Access Engine

This block is the host side of a legacy parallel ATA (IDE) bus and runs one register access at a time at the slowest programmed-I/O timing. A request names the chip-select pair, a 3-bit register address, the direction and whether the access is 8 or 16 bits wide. For a write it also carries the data. The engine drives the address and chip selects for a setup phase. It then pulses the read or write strobe for a strobe phase and holds the address through a hold phase. It ends the access with a single-cycle done pulse, and on reads that pulse comes with the captured data.

Every control line on the bus is active low. Each one is kept inside the block as an active-high register bit and inverted at the pin, so a cleared control register leaves every strobe, every chip select and the bus reset line inactive. The bus reset line is driven directly from a host input. The tri-state data bus is given as output data plus one output enable per byte, and the high byte is enabled only for a 16-bit write to the data register. Phase lengths are parameters. Their defaults, counted in cycles of a 250 MHz clock, give at least 70 ns of setup, 165 ns of strobe and a 600 ns total cycle.

Top module: `ide_pio_engine`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `ata_cs0_n`, `ata_cs1_n`, `ata_rd_n`, `ata_wr_n` and `ata_reset_n` are 1, both data output enables are 0, and `busy` and `rsp_done` are 0.
- R2: A read accepted at a clock edge drives the chip selects and address for SETUP_CYC cycles with `ata_rd_n` high. It then holds `ata_rd_n` low for STROBE_CYC cycles and keeps the chip selects and address for HOLD_CYC more cycles with `ata_rd_n` high. In the next cycle `rsp_done` is 1 and the chip selects are 1 again.
- R3: Read data is taken from `ata_data_in` at the clock edge that ends the last strobe cycle, and it is presented on `rsp_rdata` while `rsp_done` is 1.
- R4: A write follows the same three phase lengths, using `ata_wr_n` as the strobe. From the first setup cycle through the last hold cycle, `ata_oe_lo` is 1 and `ata_data_out[7:0]` equals the low byte of the write data.
- R5: In an 8-bit access, `ata_oe_hi` stays 0 on writes, and on reads `rsp_rdata[15:8]` is 0 whatever the bus carries.
- R6: An access is 16 bits wide only when `req_wide` is 1, `req_cs` is 2'b01 and `req_addr` is 3'b000 (the data register). In that case a write drives `ata_oe_hi` with `ata_data_out[15:8]` equal to the high write byte, and a read returns all 16 bits. A wide request to any other register behaves as an 8-bit access.
- R7: Both data output enables are 0 whenever `ata_rd_n` is 0 and whenever the engine is idle.
- R8: A request is accepted only while `busy` is 0. A `req_valid` seen while busy changes neither the pins of the running access nor starts a later one.
- R9: `rsp_done` is 1 for exactly one cycle per completed access.
- R10: `ata_reset_n` equals the inverse of `host_reset` as sampled one clock earlier, whatever access is in progress, and it is held at 1 while `rst_n` is low.
- R11: `req_cs` bit 0 set drives `ata_cs0_n` low and bit 1 set drives `ata_cs1_n` low during the access, and `ata_addr` carries `req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_wide | input | 1 | Ask for a 16-bit access |
| req_cs | input | 2 | Bit 0 selects /CS0, bit 1 selects /CS1 |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| host_reset | input | 1 | 1 asserts the bus reset line |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_addr | output | 3 | Register address lines |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_reset_n | output | 1 | Bus reset, active low |
| ata_data_out | output | 16 | Data toward the bus |
| ata_oe_lo | output | 1 | Output enable for data bits 7..0 |
| ata_oe_hi | output | 1 | Output enable for data bits 15..8 |
| ata_data_in | input | 16 | Data from the bus |

## Verification
Random reads and writes are spread over both chip-select pairs, all eight addresses and both width flags. The bus model returns the inverse of its word whenever the read strobe is high, so a capture taken outside the strobe shows up as a wrong value. Directed wide accesses to the data register and to a non-data register tell the real 16-bit path apart from the demoted 8-bit one. Requests injected in mid-access test whether a busy engine ignores them. Raising host reset during a transfer shows that the reset line is independent of the sequencer.

// File: rtl/ide_pio_pkg.sv
// Shared types and default timing for the IDE PIO access engine.
// Assumes a 250 MHz clock for the default phase lengths.
package ide_pio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // Active-high image of the active-low bus controls.
    typedef struct packed {
        logic bus_rst;
        logic rd;
        logic wr;
        logic cs1;
        logic cs0;
    } ctl_bits_t;

    // 18*4=72ns setup, 42*4=168ns strobe, 152*4=608ns full cycle
    localparam int unsigned DEF_SETUP_CYC  = 18;
    localparam int unsigned DEF_STROBE_CYC = 42;
    localparam int unsigned DEF_HOLD_CYC   = 92;

endpackage

// File: rtl/ide_phase_timer.sv
// Down-counter that times one phase of a bus access.
// Assumes load values are phase length minus one; expired is high on the last cycle.
module ide_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    // Load a new phase length or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/ide_ctl_pins.sv
// Registers the bus controls as active-high bits and inverts them at the pins.
// Assumes phase_nxt and the request fields describe the cycle about to start.
module ide_ctl_pins
    import ide_pio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_e     phase_nxt,
    input  logic [1:0] cs_sel,
    input  logic [2:0] addr,
    input  logic       is_write,
    input  logic       host_reset,
    output logic       ata_cs0_n,
    output logic       ata_cs1_n,
    output logic [2:0] ata_addr,
    output logic       ata_rd_n,
    output logic       ata_wr_n,
    output logic       ata_reset_n
);
    ctl_bits_t  ctl_d, ctl_q;
    logic [2:0] addr_q;
    logic       in_access;

    // Next control image from the coming phase.
    always_comb begin
        in_access     = (phase_nxt != PH_IDLE);
        ctl_d.bus_rst = host_reset;
        ctl_d.cs0     = in_access && cs_sel[0];
        ctl_d.cs1     = in_access && cs_sel[1];
        ctl_d.rd      = (phase_nxt == PH_STROBE) && !is_write;
        ctl_d.wr      = (phase_nxt == PH_STROBE) && is_write;
    end

    // Control and address registers; reset clears every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            addr_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            addr_q <= in_access ? addr : 3'b000;
        end
    end

    assign ata_cs0_n   = ~ctl_q.cs0;
    assign ata_cs1_n   = ~ctl_q.cs1;
    assign ata_rd_n    = ~ctl_q.rd;
    assign ata_wr_n    = ~ctl_q.wr;
    assign ata_reset_n = ~ctl_q.bus_rst;
    assign ata_addr    = addr_q;
endmodule

// File: rtl/ide_data_path.sv
// Write data drive with per-byte enables and read capture with width masking.
// Assumes 'wide' is already restricted to the data register by the caller.
module ide_data_path
    import ide_pio_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              is_write,
    input  logic              wide,
    input  phase_e            phase_nxt,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              oe_lo,
    output logic              oe_hi,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              oe_lo_q, oe_hi_q;

    // Hold write data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (load)
            wdata_q <= wdata;
    end

    // Enable drivers only across a write access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_lo_q <= 1'b0;
            oe_hi_q <= 1'b0;
        end else begin
            oe_lo_q <= (phase_nxt != PH_IDLE) && is_write;
            oe_hi_q <= (phase_nxt != PH_IDLE) && is_write && wide;
        end
    end

    // Sample the bus at the end of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= wide ? bus_in : {{HALF_W{1'b0}}, bus_in[HALF_W-1:0]};
    end

    assign bus_out = wdata_q;
    assign oe_lo   = oe_lo_q;
    assign oe_hi   = oe_hi_q;
    assign rdata   = rdata_q;
endmodule

// File: rtl/ide_pio_engine.sv
// Top of the IDE PIO register access engine: phase sequencer plus request latch.
// Assumes one access at a time; requests while busy are dropped.
module ide_pio_engine
    import ide_pio_pkg::*;
#(
    parameter int unsigned SETUP_CYC  = DEF_SETUP_CYC,
    parameter int unsigned STROBE_CYC = DEF_STROBE_CYC,
    parameter int unsigned HOLD_CYC   = DEF_HOLD_CYC,
    parameter int unsigned DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [1:0]        req_cs,
    input  logic [2:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              host_reset,
    output logic              busy,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ata_cs0_n,
    output logic              ata_cs1_n,
    output logic [2:0]        ata_addr,
    output logic              ata_rd_n,
    output logic              ata_wr_n,
    output logic              ata_reset_n,
    output logic [DATA_W-1:0] ata_data_out,
    output logic              ata_oe_lo,
    output logic              ata_oe_hi,
    input  logic [DATA_W-1:0] ata_data_in
);
    localparam int unsigned MAX_A  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int unsigned MAX_PH = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int unsigned CNT_W  = $clog2(MAX_PH + 1);

    phase_e           phase_q, phase_d;
    logic             tmr_load, tmr_expired, accept, capture, finish;
    logic [CNT_W-1:0] tmr_val;
    logic             wr_q, wide_q, done_q;
    logic [1:0]       cs_q;
    logic [2:0]       addr_q;
    logic             cur_write, cur_wide, req_wide_eff;
    logic [1:0]       cur_cs;
    logic [2:0]       cur_addr;

    // Wide only for the data register.
    assign req_wide_eff = req_wide && (req_cs == 2'b01) && (req_addr == 3'b000);

    // Fields of the access being started or continued.
    always_comb begin
        cur_write = accept ? req_write    : wr_q;
        cur_wide  = accept ? req_wide_eff : wide_q;
        cur_cs    = accept ? req_cs       : cs_q;
        cur_addr  = accept ? req_addr     : addr_q;
    end

    // Phase sequencing and timer reloads.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        finish   = 1'b0;
        unique case (phase_q)
            PH_IDLE: if (req_valid) begin
                accept   = 1'b1;
                phase_d  = PH_SETUP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETUP_CYC - 1);
            end
            PH_SETUP: if (tmr_expired) begin
                phase_d  = PH_STROBE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(STROBE_CYC - 1);
            end
            PH_STROBE: if (tmr_expired) begin
                capture  = !wr_q;
                phase_d  = PH_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HOLD_CYC - 1);
            end
            PH_HOLD: if (tmr_expired) begin
                finish  = 1'b1;
                phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase state, request latch and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            cs_q    <= 2'b00;
            addr_q  <= 3'b000;
            done_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= finish;
            if (accept) begin
                wr_q   <= req_write;
                wide_q <= req_wide_eff;
                cs_q   <= req_cs;
                addr_q <= req_addr;
            end
        end
    end

    ide_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ide_ctl_pins u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_nxt   (phase_d),
        .cs_sel      (cur_cs),
        .addr        (cur_addr),
        .is_write    (cur_write),
        .host_reset  (host_reset),
        .ata_cs0_n   (ata_cs0_n),
        .ata_cs1_n   (ata_cs1_n),
        .ata_addr    (ata_addr),
        .ata_rd_n    (ata_rd_n),
        .ata_wr_n    (ata_wr_n),
        .ata_reset_n (ata_reset_n)
    );

    ide_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .wdata     (req_wdata),
        .is_write  (cur_write),
        .wide      (cur_wide),
        .phase_nxt (phase_d),
        .capture   (capture),
        .bus_in    (ata_data_in),
        .bus_out   (ata_data_out),
        .oe_lo     (ata_oe_lo),
        .oe_hi     (ata_oe_hi),
        .rdata     (rsp_rdata)
    );

    assign busy     = (phase_q != PH_IDLE);
    assign rsp_done = done_q;
endmodule

// File: rtl/ide_pio_engine_chk.sv
// Protocol checker for the IDE PIO engine, bound to every instance of the top.
// Assumes it sees only the top module's ports.
module ide_pio_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_reset,
    input logic       rsp_done,
    input logic       ata_cs0_n,
    input logic       ata_cs1_n,
    input logic [2:0] ata_addr,
    input logic       ata_rd_n,
    input logic       ata_wr_n,
    input logic       ata_reset_n,
    input logic       ata_oe_lo,
    input logic       ata_oe_hi
);
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_rd_n |-> !(ata_oe_lo || ata_oe_hi)); // R7
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !ata_rd_n |-> ata_wr_n); // R2
    AST_STROBE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> (!ata_cs0_n || !ata_cs1_n)); // R11
    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ata_rd_n || !ata_wr_n) |-> ($stable(ata_addr) && $stable(ata_cs0_n) && $stable(ata_cs1_n))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9
    AST_HI_BYTE_DATA_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ata_oe_hi |-> (ata_oe_lo && ata_addr == 3'b000 && !ata_cs0_n && ata_cs1_n)); // R6
    AST_RESET_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset |=> !ata_reset_n); // R10
endmodule

bind ide_pio_engine ide_pio_engine_chk u_chk (.*);

// File: tb/ide_pio_engine_tb.sv
`timescale 1ns/1ps
module ide_pio_engine_tb;
    localparam int unsigned SETUP_CYC  = 18;
    localparam int unsigned STROBE_CYC = 42;
    localparam int unsigned HOLD_CYC   = 92;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [1:0]  req_cs = 2'b00;
    logic [2:0]  req_addr = 3'b000;
    logic [15:0] req_wdata = 16'h0000;
    logic        host_reset = 1'b0;
    logic        busy, rsp_done;
    logic [15:0] rsp_rdata, ata_data_out, ata_data_in;
    logic        ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n, ata_reset_n, ata_oe_lo, ata_oe_hi;
    logic [2:0]  ata_addr;
    logic [15:0] dev_word = 16'h1234;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    // Bus model: valid word only while the read strobe is low.
    assign ata_data_in = ata_rd_n ? ~dev_word : dev_word;

    ide_pio_engine #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
        .host_reset(host_reset), .busy(busy), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_addr(ata_addr),
        .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_reset_n(ata_reset_n),
        .ata_data_out(ata_data_out), .ata_oe_lo(ata_oe_lo), .ata_oe_hi(ata_oe_hi),
        .ata_data_in(ata_data_in)
    );

    function automatic logic exp_wide(input logic w, input logic [1:0] cs, input logic [2:0] a);
        return w && cs == 2'b01 && a == 3'b000;
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [15:0] dev, input logic wide);
        return wide ? dev : {8'h00, dev[7:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_pins(input string req);
        check(ata_cs0_n && ata_cs1_n && ata_rd_n && ata_wr_n, req, "controls idle",
              {ata_cs0_n, ata_cs1_n, ata_rd_n, ata_wr_n}, 4'hF);
        check(!ata_oe_lo && !ata_oe_hi, req, "oe idle", {ata_oe_lo, ata_oe_hi}, 0);
    endtask

    // One access, measured at negedges; optional request injected while busy.
    task automatic xfer(input logic w, input logic wd, input logic [1:0] cs,
                        input logic [2:0] a, input logic [15:0] wdat, input bit inject);
        logic weff = exp_wide(wd, cs, a);
        int   n_setup = 0, n_strobe = 0, n_hold = 0, bad_sel = 0, bad_oe = 0, bad_data = 0, other = 0;
        int   idx = 0;
        dev_word = $urandom;
        req_valid = 1'b1; req_write = w; req_wide = wd; req_cs = cs; req_addr = a; req_wdata = wdat;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done && idx < 1000) begin
            logic strobe = w ? !ata_wr_n : !ata_rd_n;
            if (w ? !ata_rd_n : !ata_wr_n) other++;
            if (!strobe && n_strobe == 0) n_setup++;
            else if (strobe) n_strobe++;
            else n_hold++;
            if (ata_cs0_n != !cs[0] || ata_cs1_n != !cs[1] || ata_addr != a) bad_sel++;
            if (w) begin
                if (!ata_oe_lo || ata_oe_hi != weff) bad_oe++;
                if (ata_data_out[7:0] != wdat[7:0] || (weff && ata_data_out[15:8] != wdat[15:8])) bad_data++;
            end else if (ata_oe_lo || ata_oe_hi) bad_oe++;
            if (inject) begin
                req_valid = (idx == 3 || idx == SETUP_CYC + 2);
                req_write = !w; req_addr = a ^ 3'b111; req_cs = ~cs; req_wide = 1'b1;
            end
            idx++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(n_setup == SETUP_CYC, w ? "R4" : "R2", "setup cycles", n_setup, SETUP_CYC);
        check(n_strobe == STROBE_CYC, w ? "R4" : "R2", "strobe cycles", n_strobe, STROBE_CYC);
        check(n_hold == HOLD_CYC, w ? "R4" : "R2", "hold cycles", n_hold, HOLD_CYC);
        check(other == 0, "R2", "wrong strobe active", other, 0);
        check(bad_sel == 0, inject ? "R8" : "R11", "select/address during access", bad_sel, 0);
        check(bad_oe == 0, w ? (weff ? "R6" : "R5") : "R7", "output enables", bad_oe, 0);
        if (w) check(bad_data == 0, weff ? "R6" : "R4", "write data on bus", bad_data, 0);
        check(rsp_done, "R2", "done after hold", rsp_done, 1);
        if (!w) check(rsp_rdata == exp_rdata(dev_word, weff), weff ? "R6" : (wd ? "R6" : "R3"),
                      "read data", rsp_rdata, exp_rdata(dev_word, weff));
        idle_pins("R7");
        @(negedge clk);
        check(!rsp_done, "R9", "done one cycle", rsp_done, 0);
        if (inject) begin
            for (int i = 0; i < 20; i++) @(negedge clk);
            check(!busy && ata_cs0_n && ata_cs1_n, "R8", "no access started while busy",
                  {busy, ata_cs0_n, ata_cs1_n}, 3'b011);
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        host_reset = 1'b1;
        repeat (4) @(negedge clk);
        idle_pins("R1");
        check(ata_reset_n && !busy && !rsp_done, "R1", "reset state", {ata_reset_n, busy, rsp_done}, 3'b100);
        check(ata_reset_n, "R10", "bus reset held off in rst", ata_reset_n, 1);
        host_reset = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_pins("R1");
        check(ata_reset_n && !busy, "R1", "first cycle out of reset", {ata_reset_n, busy}, 2'b10);

        // Directed corners.
        xfer(1'b1, 1'b1, 2'b01, 3'd0, 16'hBEEF, 1'b0);
        xfer(1'b0, 1'b1, 2'b01, 3'd0, 16'h0000, 1'b0);
        xfer(1'b1, 1'b1, 2'b01, 3'd7, 16'hC35A, 1'b0);
        xfer(1'b0, 1'b1, 2'b10, 3'd6, 16'h0000, 1'b0);
        xfer(1'b0, 1'b0, 2'b01, 3'd0, 16'h0000, 1'b0);
        xfer(1'b1, 1'b0, 2'b01, 3'd0, 16'hF00D, 1'b1);
        xfer(1'b0, 1'b0, 2'b10, 3'd7, 16'h0000, 1'b1);

        // Bus reset during an access.
        req_valid = 1'b1; req_write = 1'b0; req_cs = 2'b01; req_addr = 3'd2; req_wide = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        host_reset = 1'b1;
        @(negedge clk);
        check(!ata_reset_n && busy, "R10", "bus reset asserted mid-access", {ata_reset_n, busy}, 2'b01);
        host_reset = 1'b0;
        @(negedge clk);
        check(ata_reset_n, "R10", "bus reset released", ata_reset_n, 1);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);

        // Random accesses.
        for (int n = 0; n < 60; n++) begin
            logic [1:0] cs = ($urandom % 2) ? 2'b10 : 2'b01;
            logic [2:0] a  = ($urandom % 4 == 0) ? 3'd0 : 3'($urandom);
            xfer(1'($urandom), 1'($urandom), cs, a, 16'($urandom), (n % 10) == 5);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule